// File: doc/BRIEF.md
# Voltage-Frequency Operating Point Sequencer

This block steps one clock domain between four voltage-frequency operating levels. Software writes a target level index through a small register port. The sequencer looks up that level's supply code and clock select, then issues requests to an external regulator and an external clock generator. It waits for a completion handshake after each request. The order of the two requests depends on the direction of the move. Going up, the supply must be high enough before the clock speeds up. Going down, the clock must slow before the supply drops.

Each wait runs against a programmable cycle limit. Regulator settling can take many microseconds, so the limit is a register and not a fixed short delay. If a handshake does not arrive within the limit, the sequencer raises an error and stops. The outputs keep the last values already applied, and the reported level stays at the last level that completed. A target written while a move is in flight is held and serviced afterwards.

Top module: `opp_sequencer`

## Requirements
- R1: After reset the reported level is 0, busy and error are 0, the supply code output is 69 and the clock select output is 1.
- R2: Level n (0 slowest, 3 fastest) maps to clock select n+1, in units of 75 MHz. It maps to supply code 69, 81, 103 or 121 for n = 0, 1, 2 or 3, in units of 10 mV. The supply code output changes only in a cycle where the supply request is high.
- R3: For a move to a higher level, a one-cycle supply request goes out first. The clock request follows only after the supply-settled pulse. The two requests are never high in the same cycle.
- R4: For a move to a lower level, a one-cycle clock request goes out first. The supply request follows only after the clock-locked pulse.
- R5: A target equal to the current level completes with a done pulse one cycle after it is taken, with no supply or clock request.
- R6: A target written while busy is held and serviced after the running move completes. A later write made while busy replaces an earlier held one.
- R7: If the awaited handshake does not arrive within the timeout limit, the sequencer sets error and clears busy, and the reported level is unchanged. The timeout limit resets to 1000. The next target write clears error and starts a new move.
- R8: Register map. Writing address 0 sets the target level from data bits 1:0. Writing address 1 sets the timeout limit. Reading address 0 returns the level in bits 1:0, busy in bit 2 and error in bit 3. Reading address 1 returns the timeout limit.
- R9: Done is a one-cycle pulse. It comes in the same cycle the reported level takes the new value, and busy is 0 in that cycle.
- R10: A settled or locked pulse that arrives while the sequencer is not waiting for it has no effect on level, busy, error or done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| vreg_req | output | 1 | One-cycle supply change request |
| vreg_code | output | 8 | Requested supply code, 10 mV units |
| vreg_settled | input | 1 | Regulator settled pulse |
| clk_req | output | 1 | One-cycle clock change request |
| clk_sel | output | 3 | Requested clock select, 75 MHz units |
| clk_locked | input | 1 | Clock generator locked pulse |
| busy | output | 1 | A move is in progress |
| done | output | 1 | One-cycle pulse when a move completes |

## Verification
A wrong sequencer state shows on the request pins one cycle after the target is taken, as a supply request where a clock request belongs or the reverse. It also shows as a code that does not match the level. A lost or corrupted held target shows only later, as a final level or done count that differs from the latest write, after the running move finishes. A broken timeout shows as error missing, or error raised at a level that moved, once the limit expires. A missed ignore of a stray handshake shows as a level or done change in the cycle after the pulse.

// File: rtl/opp_pkg.sv
package opp_pkg;
  localparam int LVL_W = 2;
  localparam int NUM_LVL = 1 << LVL_W;
  localparam int VC_W = 8;
  localparam int FS_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_UP_V = 3'd1,
    ST_UP_F = 3'd2,
    ST_DN_F = 3'd3,
    ST_DN_V = 3'd4,
    ST_ERR  = 3'd5
  } seq_state_t;

  // supply code in 10 mV steps
  function automatic logic [VC_W-1:0] lvl_vcode(input logic [LVL_W-1:0] lvl);
    case (lvl)
      2'd0:    return VC_W'(69);
      2'd1:    return VC_W'(81);
      2'd2:    return VC_W'(103);
      default: return VC_W'(121);
    endcase
  endfunction

  // clock select in 75 MHz steps
  function automatic logic [FS_W-1:0] lvl_fsel(input logic [LVL_W-1:0] lvl);
    return FS_W'(lvl) + FS_W'(1);
  endfunction
endpackage

// File: rtl/opp_timeout.sv
module opp_timeout #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  logic [CNT_W-1:0] cnt;

  assign hit = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clear)        cnt <= '0;
    else if (run && !hit)  cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/opp_regif.sv
module opp_regif
  import opp_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int TMO_DEFAULT = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             take,
  input  logic [LVL_W-1:0] cur_lvl,
  input  logic             busy,
  input  logic             err,
  output logic             pend_vld,
  output logic [LVL_W-1:0] pend_lvl,
  output logic [REG_W-1:0] tmo_limit
);
  localparam logic [1:0] A_TARGET = 2'd0;
  localparam logic [1:0] A_TMO    = 2'd1;

  logic wr_target, wr_tmo;
  assign wr_target = reg_wr && (reg_addr == A_TARGET);
  assign wr_tmo    = reg_wr && (reg_addr == A_TMO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_lvl  <= '0;
      tmo_limit <= REG_W'(TMO_DEFAULT);
    end else begin
      // a write in the same cycle as a take stays held
      if (wr_target) begin
        pend_vld <= 1'b1;
        pend_lvl <= reg_wdata[LVL_W-1:0];
      end else if (take) begin
        pend_vld <= 1'b0;
      end
      if (wr_tmo) tmo_limit <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      A_TARGET: reg_rdata = REG_W'({err, busy, cur_lvl});
      A_TMO:    reg_rdata = tmo_limit;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/opp_fsm.sv
module opp_fsm
  import opp_pkg::*;
#(
  parameter logic [1:0] RESET_LVL = 2'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend_vld,
  input  logic [LVL_W-1:0] pend_lvl,
  input  logic             vreg_settled,
  input  logic             clk_locked,
  input  logic             tmo_hit,
  output logic             take,
  output logic             start_up,
  output logic             start_dn,
  output logic             start_same,
  output logic             ack_seen,
  output logic             waiting,
  output seq_state_t       state,
  output logic [LVL_W-1:0] cur_lvl,
  output logic             vreg_req,
  output logic [VC_W-1:0]  vreg_code,
  output logic             clk_req,
  output logic [FS_W-1:0]  clk_sel,
  output logic             done,
  output logic             err_flag
);
  logic [LVL_W-1:0] tgt_lvl;
  logic wait_volt, wait_clk;

  assign wait_volt = (state == ST_UP_V) || (state == ST_DN_V);
  assign wait_clk  = (state == ST_UP_F) || (state == ST_DN_F);
  assign waiting   = wait_volt || wait_clk;
  assign ack_seen  = (wait_volt && vreg_settled) || (wait_clk && clk_locked);

  assign take       = pend_vld && ((state == ST_IDLE) || (state == ST_ERR));
  assign start_same = take && (pend_lvl == cur_lvl);
  assign start_up   = take && (pend_lvl >  cur_lvl);
  assign start_dn   = take && (pend_lvl <  cur_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_lvl   <= RESET_LVL;
      tgt_lvl   <= RESET_LVL;
      vreg_req  <= 1'b0;
      vreg_code <= lvl_vcode(RESET_LVL);
      clk_req   <= 1'b0;
      clk_sel   <= lvl_fsel(RESET_LVL);
      done      <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      vreg_req <= 1'b0;
      clk_req  <= 1'b0;
      done     <= 1'b0;
      case (state)
        ST_IDLE, ST_ERR: begin
          if (take) begin
            err_flag <= 1'b0;
            tgt_lvl  <= pend_lvl;
            if (start_up) begin
              vreg_req  <= 1'b1;
              vreg_code <= lvl_vcode(pend_lvl);
              state     <= ST_UP_V;
            end else if (start_dn) begin
              clk_req <= 1'b1;
              clk_sel <= lvl_fsel(pend_lvl);
              state   <= ST_DN_F;
            end else begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end
          end
        end
        ST_UP_V: begin
          if (ack_seen) begin
            clk_req <= 1'b1;
            clk_sel <= lvl_fsel(tgt_lvl);
            state   <= ST_UP_F;
          end else if (tmo_hit) begin
            err_flag <= 1'b1;
            state    <= ST_ERR;
          end
        end
        ST_DN_F: begin
          if (ack_seen) begin
            vreg_req  <= 1'b1;
            vreg_code <= lvl_vcode(tgt_lvl);
            state     <= ST_DN_V;
          end else if (tmo_hit) begin
            err_flag <= 1'b1;
            state    <= ST_ERR;
          end
        end
        ST_UP_F, ST_DN_V: begin
          if (ack_seen) begin
            cur_lvl <= tgt_lvl;
            done    <= 1'b1;
            state   <= ST_IDLE;
          end else if (tmo_hit) begin
            err_flag <= 1'b1;
            state    <= ST_ERR;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/opp_sequencer.sv
module opp_sequencer
  import opp_pkg::*;
#(
  parameter int TMO_W = 16,
  parameter int TMO_DEFAULT = 1000,
  parameter logic [1:0] RESET_LVL = 2'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [TMO_W-1:0] reg_wdata,
  output logic [TMO_W-1:0] reg_rdata,
  output logic             vreg_req,
  output logic [VC_W-1:0]  vreg_code,
  input  logic             vreg_settled,
  output logic             clk_req,
  output logic [FS_W-1:0]  clk_sel,
  input  logic             clk_locked,
  output logic             busy,
  output logic             done
);
  logic             take, start_up, start_dn, start_same, ack_seen, waiting;
  logic             tmo_hit, err_flag, pend_vld;
  logic [LVL_W-1:0] pend_lvl, cur_lvl;
  logic [TMO_W-1:0] tmo_limit;
  seq_state_t       state;

  assign busy = (state != ST_IDLE) && (state != ST_ERR);

  opp_regif #(.REG_W(TMO_W), .TMO_DEFAULT(TMO_DEFAULT)) regif_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .take(take),
    .cur_lvl(cur_lvl), .busy(busy), .err(err_flag),
    .pend_vld(pend_vld), .pend_lvl(pend_lvl), .tmo_limit(tmo_limit)
  );

  opp_timeout #(.CNT_W(TMO_W)) tmo_i (
    .clk(clk), .rst_n(rst_n), .clear(!waiting || ack_seen),
    .run(waiting && !ack_seen), .limit(tmo_limit), .hit(tmo_hit)
  );

  opp_fsm #(.RESET_LVL(RESET_LVL)) fsm_i (
    .clk(clk), .rst_n(rst_n), .pend_vld(pend_vld), .pend_lvl(pend_lvl),
    .vreg_settled(vreg_settled), .clk_locked(clk_locked), .tmo_hit(tmo_hit),
    .take(take), .start_up(start_up), .start_dn(start_dn),
    .start_same(start_same), .ack_seen(ack_seen), .waiting(waiting),
    .state(state), .cur_lvl(cur_lvl), .vreg_req(vreg_req),
    .vreg_code(vreg_code), .clk_req(clk_req), .clk_sel(clk_sel),
    .done(done), .err_flag(err_flag)
  );
endmodule

// File: rtl/opp_sequencer_chk.sv
module opp_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vreg_req,
  input logic       clk_req,
  input logic [7:0] vreg_code,
  input logic       done,
  input logic       busy,
  input logic       err_flag,
  input logic       start_up,
  input logic       start_dn,
  input logic       start_same,
  input logic       tmo_hit,
  input logic [1:0] cur_lvl
);
  assert_volt_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_up |=> vreg_req && !clk_req);
  assert_no_dual_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(vreg_req && clk_req));
  assert_clk_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_dn |=> clk_req && !vreg_req);
  assert_same_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_same |=> done && !vreg_req && !clk_req);
  assert_code_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !vreg_req |-> $stable(vreg_code));
  assert_tmo_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> err_flag && !busy);
  assert_status_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && err_flag));
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_level_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_lvl) |-> done);
endmodule

bind opp_sequencer opp_sequencer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .vreg_req(vreg_req), .clk_req(clk_req),
  .vreg_code(vreg_code), .done(done), .busy(busy), .err_flag(err_flag),
  .start_up(start_up), .start_dn(start_dn), .start_same(start_same),
  .tmo_hit(tmo_hit), .cur_lvl(cur_lvl)
);

// File: tb/opp_sequencer_tb.sv
module opp_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        vreg_req, clk_req, busy, done;
  logic [7:0]  vreg_code;
  logic [2:0]  clk_sel;
  logic        vreg_settled = 1'b0;
  logic        clk_locked = 1'b0;

  int n_chk = 0, n_fail = 0;
  int v_delay = 3, c_delay = 3;
  logic v_force = 1'b0, c_force = 1'b0;
  int v_cnt = 0, c_cnt = 0;
  int log_n = 0, done_cnt = 0;
  int log_kind [0:511];
  int log_val [0:511];
  int exp_lvl = 0;

  always #5 clk = ~clk;

  opp_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vreg_req(vreg_req),
    .vreg_code(vreg_code), .vreg_settled(vreg_settled), .clk_req(clk_req),
    .clk_sel(clk_sel), .clk_locked(clk_locked), .busy(busy), .done(done)
  );

  function automatic int bench_mv(input int l);
    int mv [4] = '{690, 810, 1030, 1210};
    return mv[l];
  endfunction
  function automatic int bench_vcode(input int l);
    return bench_mv(l) / 10;
  endfunction
  function automatic int bench_sel(input int l);
    return (75 * (l + 1)) / 75;
  endfunction

  // responders and request log
  always @(negedge clk) begin
    logic vs, cl;
    vs = v_force;
    cl = c_force;
    if (done) done_cnt++;
    if (vreg_req && clk_req) begin
      n_chk++; n_fail++;
      $display("FAIL R3: both requests high, act=1 exp=0");
    end
    if (vreg_req) begin
      log_kind[log_n] = 0; log_val[log_n] = int'(vreg_code); log_n++;
      v_cnt = v_delay;
    end else if (v_cnt > 0) begin
      if (v_cnt == 1) vs = 1'b1;
      v_cnt--;
    end
    if (clk_req) begin
      log_kind[log_n] = 1; log_val[log_n] = int'(clk_sel); log_n++;
      c_cnt = c_delay;
    end else if (c_cnt > 0) begin
      if (c_cnt == 1) cl = 1'b1;
      c_cnt--;
    end
    vreg_settled <= vs;
    clk_locked <= cl;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    reg_addr = 2'(a);
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic move(input int tgt, input string req);
    int base, st, cycles, cur;
    bit seen;
    base = log_n; cur = exp_lvl; seen = 0;
    wr(0, tgt);
    for (int i = 0; i < 3000 && !seen; i++) begin
      if (done) begin
        seen = 1;
        rd(0, st);
        chk((st & 3) == tgt && ((st >> 2) & 1) == 0, {req, "/R9"}, st & 7, tgt);
      end else @(negedge clk);
    end
    chk(seen, req, int'(seen), 1);
    rd(0, st);
    chk(st == tgt, {req, "/R8"}, st, tgt);
    if (tgt > cur) begin
      chk(log_n - base == 2 && log_kind[base] == 0 && log_val[base] == bench_vcode(tgt)
          && log_kind[base+1] == 1 && log_val[base+1] == bench_sel(tgt),
          "R3", log_kind[base], 0);
    end else if (tgt < cur) begin
      chk(log_n - base == 2 && log_kind[base] == 1 && log_val[base] == bench_sel(tgt)
          && log_kind[base+1] == 0 && log_val[base+1] == bench_vcode(tgt),
          "R4", log_kind[base], 1);
    end else begin
      chk(log_n == base, "R5", log_n - base, 0);
    end
    chk(int'(vreg_code) == bench_vcode(tgt) && int'(clk_sel) == bench_sel(tgt),
        "R2", int'(vreg_code), bench_vcode(tgt));
    exp_lvl = tgt;
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int st, base, d0, t;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(0, st);
    chk(st == 0, "R1", st, 0);
    chk(int'(vreg_code) == 69 && int'(clk_sel) == 1, "R1", int'(vreg_code), 69);
    rd(1, st);
    chk(st == 1000, "R7", st, 1000);

    // R5 same level
    move(0, "R5");
    // directed up and down
    move(3, "R3");
    move(0, "R4");
    move(2, "R3");

    // R10 stray handshakes while idle
    base = log_n; d0 = done_cnt;
    @(negedge clk); v_force = 1'b1; c_force = 1'b1;
    @(negedge clk); v_force = 1'b0; c_force = 1'b0;
    repeat (4) @(negedge clk);
    rd(0, st);
    chk(st == 2 && done_cnt == d0 && log_n == base, "R10", st, 2);

    // R6 writes during busy: latest held target wins
    v_delay = 20; c_delay = 20;
    move(0, "R4");
    base = log_n; d0 = done_cnt;
    wr(0, 3);
    repeat (3) @(negedge clk);
    wr(0, 1);
    wr(0, 2);
    repeat (200) @(negedge clk);
    rd(0, st);
    chk(st == 2, "R6", st, 2);
    chk(done_cnt - d0 == 2, "R6", done_cnt - d0, 2);
    chk(log_n - base == 4 && log_kind[base] == 0 && log_kind[base+1] == 1
        && log_kind[base+2] == 1 && log_val[base+2] == bench_sel(2)
        && log_kind[base+3] == 0 && log_val[base+3] == bench_vcode(2),
        "R6", log_n - base, 4);
    exp_lvl = 2;

    // R7 timeout going up
    v_delay = 50; c_delay = 3;
    wr(1, 10);
    rd(1, st);
    chk(st == 10, "R8", st, 10);
    wr(0, 3);
    t = 0;
    do begin @(negedge clk); rd(0, st); t++; end while (((st >> 2) & 1) == 1 && t < 300);
    chk(st == (8 | 2), "R7", st, 10);
    repeat (80) @(negedge clk);
    rd(0, st);
    chk(st == (8 | 2), "R10", st, 10);
    wr(1, 1000);
    v_delay = 5;
    move(3, "R7");

    // R7 timeout going down
    c_delay = 60;
    wr(1, 10);
    wr(0, 1);
    t = 0;
    do begin @(negedge clk); rd(0, st); t++; end while (((st >> 2) & 1) == 1 && t < 300);
    chk(st == (8 | 3), "R7", st, 11);
    repeat (80) @(negedge clk);
    wr(1, 1000);
    c_delay = 4;
    move(1, "R7");

    // random moves
    for (int i = 0; i < 24; i++) begin
      v_delay = 1 + int'($urandom % 30);
      c_delay = 1 + int'($urandom % 30);
      move(int'($urandom % 4), "R2");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule